// File: doc/BRIEF.md
# Lockable GPIO register file

This block is the memory-mapped control register bank that sits in front of a 32-pin general-purpose I/O controller. A host accesses it with word-aligned 32-bit reads and writes over a simple valid/write strobe interface. It holds the per-pin configuration: inversion, output data, output enable, open-drain select, pull-up, pull-down, input mask, event type, both-edge select, event enable, slew and drive strength. It drives each of these straight out to the pin and event logic that sit beside it.

Three features keep software simple and safe. Output data, output enable and event enable each have a set alias and a clear alias, so single bits can change without a read-modify-write. Event status bits are sticky: the neighbouring event logic raises them, and software clears them by writing ones. A global write lock freezes the whole bank. Writing either lock word engages it, and only a two-step key sequence releases it.

When a write changes pin configuration, the bank raises a one-cycle re-evaluation strobe and a mask of the bits that changed, so that the pin resolver can update. Every access gets a response one cycle later. Reads return data with a valid pulse, and bad accesses raise a one-cycle error flag.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the bank is unlocked, event status is 0, and every register is 0 except pull-up, pull-down, slew and drive, which take the parameters RST_PULL_UP, RST_PULL_DN, RST_SLEW and RST_DRIVE.
- R2: Readable registers sit at these byte offsets: inversion 0x0C, output data 0x10, output enable 0x1C, open-drain 0x28, pull-up 0x2C, pull-down 0x30, input mask 0x34, event type 0x38, both-edge 0x3C, event enable 0x40, event status 0x4C, slew 0x50, drive 0x54. A write updates the matching cfg_* output at the next edge. A read returns bus_rdata with bus_rvalid high one cycle after the access.
- R3: Set aliases OR the written word into their target and clear aliases AND the target with its inverse. The offsets are 0x14/0x18 for output data, 0x20/0x24 for output enable and 0x44/0x48 for event enable.
- R4: Each evt_hit bit sets the matching evt_status bit at the next edge, and the bit stays set. Writing 1s to 0x4C clears those bits. A hit in the same cycle as a clear of the same bit wins.
- R5: Offset 0x08 reads the live pin_in_level word. A write to it raises bus_err and has no effect.
- R6: While unlocked, a write of any value to either lock word (0x00 or 0x04) engages the lock and raises no error.
- R7: While locked, every write other than to the two lock words is discarded and raises bus_err.
- R8: While locked, a write to 0x04 stores its value. A write of 0xC0DEFA73 to 0x00 releases the lock and clears the stored word, but only if 0x04 already holds 0xC0DE1248. Any other key or order leaves the bank locked.
- R9: A read of a lock word or of any set or clear alias returns 0 and raises bus_err.
- R10: An access to a misaligned address or to an offset of 0x70 or above reads 0, changes nothing and raises bus_err. Offsets 0x58 to 0x6C accept writes without effect and read 0 with no error.
- R11: One cycle after an accepted write to inversion, output data, output enable, open-drain, pull-up, pull-down, input mask or the data/enable aliases, pin_eval is high and pin_changed holds old XOR new of that register. Other writes leave pin_eval low and pin_changed zero.
- R12: bus_err is a single-cycle pulse that arrives in the cycle after the offending access, alongside any read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after access |
| bus_rvalid | output | 1 | Read response pulse |
| bus_err | output | 1 | Illegal access pulse |
| pin_in_level | input | 32 | Input level word from pin logic |
| evt_hit | input | 32 | Event detections from event logic |
| cfg_pol | output | 32 | Inversion |
| cfg_dout | output | 32 | Output data |
| cfg_oe | output | 32 | Output enable |
| cfg_otype | output | 32 | Open-drain select |
| cfg_pull_up | output | 32 | Pull-up enable |
| cfg_pull_dn | output | 32 | Pull-down enable |
| cfg_in_mask | output | 32 | Input mask |
| cfg_evt_type | output | 32 | Event type (edge vs level) |
| cfg_evt_both | output | 32 | Both-edge select |
| cfg_evt_en | output | 32 | Event enable |
| cfg_slew | output | 32 | Slew select |
| cfg_drive | output | 32 | Drive strength select |
| evt_status | output | 32 | Sticky event status |
| pin_eval | output | 1 | Pin re-evaluation strobe |
| pin_changed | output | 32 | Bits changed by that write |

## Verification
On every cycle the assertions check several properties. Set and clear aliases leave their bits set or cleared. Hits always land in the status word. The lock can fall only right after the correct key pair, and any write to a lock word while unlocked engages it. A locked bank holds its configuration still. A nonzero change mask never appears without the strobe. The pin-input read path is also checked each cycle. Only the bench scenarios can show the concrete offset map, the reset values, the exact change masks, the error cases for each access class, and that a wrong key order or a stale second word keeps the bank locked.

// File: rtl/gpio_rb_pkg.sv
// Shared types for the GPIO register bank: config register ids,
// access classes and unlock keys. Assumes a 32-bit data path.
package gpio_rb_pkg;

    localparam int DW = 32;

    // Config registers; ids below NUM_PIN_CFG affect pin resolution.
    typedef enum logic [3:0] {
        CF_POL, CF_DOUT, CF_OE, CF_OTYPE, CF_PULLUP, CF_PULLDN, CF_INMASK,
        CF_EVTYPE, CF_EVBOTH, CF_EVEN, CF_SLEW, CF_DRIVE
    } cfg_id_e;

    localparam int NUM_CFG     = 12;
    localparam int NUM_PIN_CFG = 7;

    typedef enum logic [3:0] {
        AK_CFG, AK_SET, AK_CLR, AK_STAT, AK_PININ,
        AK_LOCKA, AK_LOCKB, AK_IGNORE, AK_BAD
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        cfg_id_e   target;
    } acc_dec_t;

    localparam logic [DW-1:0] KEY_A = 32'hC0DE_FA73;
    localparam logic [DW-1:0] KEY_B = 32'hC0DE_1248;

endpackage

// File: rtl/gpio_rb_decode.sv
// Address decoder: classifies a byte address into an access kind and,
// for config/alias accesses, the target register. Purely combinational.
// Assumes word-aligned accesses; anything else is classed as bad.
module gpio_rb_decode
    import gpio_rb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_dec_t          dec
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    int                w;

    assign widx = addr[ADDR_W-1:2];
    assign w    = int'(widx);

    // Map word index to access class and target register.
    always_comb begin
        dec.kind   = AK_BAD;
        dec.target = CF_POL;
        if (addr[1:0] == 2'b00) begin
            case (w)
                0:  dec.kind = AK_LOCKA;
                1:  dec.kind = AK_LOCKB;
                2:  dec.kind = AK_PININ;
                3:  begin dec.kind = AK_CFG; dec.target = CF_POL;    end
                4:  begin dec.kind = AK_CFG; dec.target = CF_DOUT;   end
                5:  begin dec.kind = AK_SET; dec.target = CF_DOUT;   end
                6:  begin dec.kind = AK_CLR; dec.target = CF_DOUT;   end
                7:  begin dec.kind = AK_CFG; dec.target = CF_OE;     end
                8:  begin dec.kind = AK_SET; dec.target = CF_OE;     end
                9:  begin dec.kind = AK_CLR; dec.target = CF_OE;     end
                10: begin dec.kind = AK_CFG; dec.target = CF_OTYPE;  end
                11: begin dec.kind = AK_CFG; dec.target = CF_PULLUP; end
                12: begin dec.kind = AK_CFG; dec.target = CF_PULLDN; end
                13: begin dec.kind = AK_CFG; dec.target = CF_INMASK; end
                14: begin dec.kind = AK_CFG; dec.target = CF_EVTYPE; end
                15: begin dec.kind = AK_CFG; dec.target = CF_EVBOTH; end
                16: begin dec.kind = AK_CFG; dec.target = CF_EVEN;   end
                17: begin dec.kind = AK_SET; dec.target = CF_EVEN;   end
                18: begin dec.kind = AK_CLR; dec.target = CF_EVEN;   end
                19: dec.kind = AK_STAT;
                20: begin dec.kind = AK_CFG; dec.target = CF_SLEW;   end
                21: begin dec.kind = AK_CFG; dec.target = CF_DRIVE;  end
                22, 23, 24, 25, 26, 27: dec.kind = AK_IGNORE;
                default: dec.kind = AK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/gpio_rb_field.sv
// One 32-bit config register with direct write, OR-set and AND-NOT clear.
// Exposes next value so the top can form the change mask.
// Assumes at most one of wr_en/set_en/clr_en is high per cycle.
module gpio_rb_field #(
    parameter int           W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] d_o,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Next-value selection.
    always_comb begin
        if (wr_en)       d_o = wdata;
        else if (set_en) d_o = q | wdata;
        else if (clr_en) d_o = q & ~wdata;
        else             d_o = q;
    end

    // Register with parameterized reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d_o;
    end

    assign q_o = q;

    a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(wdata)) == $past(wdata)));
    a_r3_clr_andn: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & $past(wdata)) == '0));

endmodule

// File: rtl/gpio_rb_evstat.sv
// Sticky event status: hits set bits, write-one clears, hit wins a tie.
// Assumes hit comes from event detection logic in this clock domain.
module gpio_rb_evstat #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;
    logic [W-1:0] drop;

    assign drop = clr_en ? clr_mask : '0;

    // Status update: clear first, then OR in new hits.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~drop) | hit;
    end

    assign q_o = q;

    a_r4_hit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((q & $past(hit)) == $past(hit)));

endmodule

// File: rtl/gpio_rb_lock.sv
// Global write lock. Unlocked: any lock-word write engages it. Locked:
// second word stores data; first word with KEY_A releases if second
// word holds KEY_B. Assumes write strobes are already qualified.
module gpio_rb_lock
    import gpio_rb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic [DW-1:0] wdata,
    output logic          locked
);
    logic [DW-1:0] key_b_q;
    logic          release_ok;

    assign release_ok = wr_a && (wdata == KEY_A) && (key_b_q == KEY_B);

    // Lock state and second-word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            key_b_q <= '0;
        end else if (locked) begin
            if (release_ok) begin
                locked  <= 1'b0;
                key_b_q <= '0;
            end else if (wr_b) begin
                key_b_q <= wdata;
            end
        end else if (wr_a || wr_b) begin
            locked  <= 1'b1;
            key_b_q <= '0;
        end
    end

    a_r8_release_needs_keys: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(wr_a && (wdata == KEY_A) && (key_b_q == KEY_B)));
    a_r6_engage: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && (wr_a || wr_b)) |=> locked);

endmodule

// File: rtl/gpio_regbank.sv
// Top of the lockable GPIO register bank. Decodes host accesses,
// applies lock rules, owns config registers, event status and the
// pin re-evaluation strobe. All responses are registered (1 cycle).
// Assumes one access per cycle and a single clock domain.
module gpio_regbank
    import gpio_rb_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter logic [31:0] RST_PULL_UP = 32'hA5A5_0000,
    parameter logic [31:0] RST_PULL_DN = 32'h0000_5A5A,
    parameter logic [31:0] RST_SLEW    = 32'h0F00_0000,
    parameter logic [31:0] RST_DRIVE   = 32'h0000_00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    input  logic [31:0]       pin_in_level,
    input  logic [31:0]       evt_hit,
    output logic [31:0]       cfg_pol,
    output logic [31:0]       cfg_dout,
    output logic [31:0]       cfg_oe,
    output logic [31:0]       cfg_otype,
    output logic [31:0]       cfg_pull_up,
    output logic [31:0]       cfg_pull_dn,
    output logic [31:0]       cfg_in_mask,
    output logic [31:0]       cfg_evt_type,
    output logic [31:0]       cfg_evt_both,
    output logic [31:0]       cfg_evt_en,
    output logic [31:0]       cfg_slew,
    output logic [31:0]       cfg_drive,
    output logic [31:0]       evt_status,
    output logic              pin_eval,
    output logic [31:0]       pin_changed
);
    acc_dec_t                   dec;
    logic                       wr_req, rd_req, is_lock, wr_ok, locked;
    logic                       acc_wo, pin_hit, stat_clr, err_d;
    logic [NUM_CFG-1:0]         f_wr, f_set, f_clr;
    logic [NUM_CFG-1:0][DW-1:0] cfg_q, cfg_d;
    logic [DW-1:0]              evt_q, rdata_d, diff_d;

    gpio_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign wr_req  = bus_valid && bus_write;
    assign rd_req  = bus_valid && !bus_write;
    assign is_lock = (dec.kind == AK_LOCKA) || (dec.kind == AK_LOCKB);
    assign wr_ok   = wr_req && (!locked || is_lock);
    assign acc_wo  = is_lock || (dec.kind == AK_SET) || (dec.kind == AK_CLR);

    gpio_rb_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_a   (wr_req && (dec.kind == AK_LOCKA)),
        .wr_b   (wr_req && (dec.kind == AK_LOCKB)),
        .wdata  (bus_wdata),
        .locked (locked)
    );

    // One field instance per config register, reset value by id.
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        localparam logic [DW-1:0] RV =
            (i == int'(CF_PULLUP)) ? RST_PULL_UP :
            (i == int'(CF_PULLDN)) ? RST_PULL_DN :
            (i == int'(CF_SLEW))   ? RST_SLEW    :
            (i == int'(CF_DRIVE))  ? RST_DRIVE   : '0;

        assign f_wr[i]  = wr_ok && (dec.kind == AK_CFG) && (dec.target == cfg_id_e'(i));
        assign f_set[i] = wr_ok && (dec.kind == AK_SET) && (dec.target == cfg_id_e'(i));
        assign f_clr[i] = wr_ok && (dec.kind == AK_CLR) && (dec.target == cfg_id_e'(i));

        gpio_rb_field #(.W(DW), .RST(RV)) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (f_wr[i]),
            .set_en (f_set[i]),
            .clr_en (f_clr[i]),
            .wdata  (bus_wdata),
            .d_o    (cfg_d[i]),
            .q_o    (cfg_q[i])
        );
    end

    assign stat_clr = wr_ok && (dec.kind == AK_STAT);

    gpio_rb_evstat #(.W(DW)) u_evst (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (evt_hit),
        .clr_en   (stat_clr),
        .clr_mask (bus_wdata),
        .q_o      (evt_q)
    );

    // Pin-affecting write detection and change mask of the target.
    assign pin_hit = wr_ok && ((dec.kind == AK_CFG) || (dec.kind == AK_SET) ||
                     (dec.kind == AK_CLR)) && (int'(dec.target) < NUM_PIN_CFG);
    assign diff_d  = cfg_d[dec.target] ^ cfg_q[dec.target];

    // Illegal-access classification.
    always_comb begin
        err_d = 1'b0;
        if (bus_valid) begin
            if (dec.kind == AK_BAD)                       err_d = 1'b1;
            if (rd_req && acc_wo)                         err_d = 1'b1;
            if (wr_req && (dec.kind == AK_PININ))         err_d = 1'b1;
            if (wr_req && locked && !is_lock)             err_d = 1'b1;
        end
    end

    // Read data selection.
    always_comb begin
        rdata_d = '0;
        if (rd_req) begin
            case (dec.kind)
                AK_CFG:   rdata_d = cfg_q[dec.target];
                AK_STAT:  rdata_d = evt_q;
                AK_PININ: rdata_d = pin_in_level;
                default:  rdata_d = '0;
            endcase
        end
    end

    // Registered response and strobe outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata   <= '0;
            bus_rvalid  <= 1'b0;
            bus_err     <= 1'b0;
            pin_eval    <= 1'b0;
            pin_changed <= '0;
        end else begin
            bus_rdata   <= rdata_d;
            bus_rvalid  <= rd_req;
            bus_err     <= err_d;
            pin_eval    <= pin_hit;
            pin_changed <= pin_hit ? diff_d : '0;
        end
    end

    assign cfg_pol      = cfg_q[CF_POL];
    assign cfg_dout     = cfg_q[CF_DOUT];
    assign cfg_oe       = cfg_q[CF_OE];
    assign cfg_otype    = cfg_q[CF_OTYPE];
    assign cfg_pull_up  = cfg_q[CF_PULLUP];
    assign cfg_pull_dn  = cfg_q[CF_PULLDN];
    assign cfg_in_mask  = cfg_q[CF_INMASK];
    assign cfg_evt_type = cfg_q[CF_EVTYPE];
    assign cfg_evt_both = cfg_q[CF_EVBOTH];
    assign cfg_evt_en   = cfg_q[CF_EVEN];
    assign cfg_slew     = cfg_q[CF_SLEW];
    assign cfg_drive    = cfg_q[CF_DRIVE];
    assign evt_status   = evt_q;

    a_r7_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_req && !is_lock) |=> $stable(cfg_q));
    a_r11_mask_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_changed != '0) |-> pin_eval);
    a_r5_pin_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (dec.kind == AK_PININ)) |=> (bus_rdata == $past(pin_in_level)));
    a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc_wo) |=> (bus_err && (bus_rdata == '0)));

endmodule

// File: tb/gpio_regbank_tb_top.sv
// Scoreboard bench: access tasks queue expected responses; a monitor
// pops and compares them at the negedge after they are due.
module gpio_regbank_tb_top;

    localparam logic [31:0] PU0 = 32'hA5A5_0000;
    localparam logic [31:0] PD0 = 32'h0000_5A5A;
    localparam logic [31:0] SL0 = 32'h0F00_0000;
    localparam logic [31:0] DR0 = 32'h0000_00F0;

    localparam logic [11:0] O_LKA = 12'h000, O_LKB = 12'h004, O_PIN = 12'h008;
    localparam logic [11:0] O_POL = 12'h00C, O_DOUT = 12'h010, O_DSET = 12'h014;
    localparam logic [11:0] O_DCLR = 12'h018, O_OE = 12'h01C, O_OSET = 12'h020;
    localparam logic [11:0] O_OCLR = 12'h024, O_PU = 12'h02C, O_EVT = 12'h038;
    localparam logic [11:0] O_EVEN = 12'h040, O_ESET = 12'h044, O_ECLR = 12'h048;
    localparam logic [11:0] O_STAT = 12'h04C, O_BLNK = 12'h05C, O_BAD = 12'h070;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, pin_in_level = '0, evt_hit = '0;
    logic [31:0] bus_rdata, cfg_pol, cfg_dout, cfg_oe, cfg_otype, cfg_pull_up;
    logic [31:0] cfg_pull_dn, cfg_in_mask, cfg_evt_type, cfg_evt_both, cfg_evt_en;
    logic [31:0] cfg_slew, cfg_drive, evt_status, pin_changed;
    logic        bus_rvalid, bus_err, pin_eval;

    int  cyc = 0, n_vec = 0, n_bad = 0;
    bit  finished = 0;

    typedef struct {
        int          due;
        bit          is_rd;
        logic [31:0] data;
        bit          err;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gpio_regbank #(
        .ADDR_W(12), .RST_PULL_UP(PU0), .RST_PULL_DN(PD0),
        .RST_SLEW(SL0), .RST_DRIVE(DR0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_err(bus_err), .pin_in_level(pin_in_level),
        .evt_hit(evt_hit), .cfg_pol(cfg_pol), .cfg_dout(cfg_dout), .cfg_oe(cfg_oe),
        .cfg_otype(cfg_otype), .cfg_pull_up(cfg_pull_up), .cfg_pull_dn(cfg_pull_dn),
        .cfg_in_mask(cfg_in_mask), .cfg_evt_type(cfg_evt_type),
        .cfg_evt_both(cfg_evt_both), .cfg_evt_en(cfg_evt_en), .cfg_slew(cfg_slew),
        .cfg_drive(cfg_drive), .evt_status(evt_status), .pin_eval(pin_eval),
        .pin_changed(pin_changed)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: issue one access at a negedge, queue its expected response.
    task automatic acc(bit wr, logic [11:0] a, logic [31:0] d,
                       logic [31:0] exp, bit exp_err, string tag);
        exp_t e;
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        e.due = cyc + 1; e.is_rd = !wr; e.data = exp; e.err = exp_err; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // Monitor: compare responses in the cycle they are due.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.tag, " rvalid"}, {31'b0, bus_rvalid}, {31'b0, e.is_rd});
            chk({e.tag, " err"}, {31'b0, bus_err}, {31'b0, e.err});
            if (e.is_rd) chk({e.tag, " rdata"}, bus_rdata, e.data);
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values.
        chk("R1 pol", cfg_pol, 32'h0);
        chk("R1 dout", cfg_dout, 32'h0);
        chk("R1 pu", cfg_pull_up, PU0);
        chk("R1 pd", cfg_pull_dn, PD0);
        chk("R1 slew", cfg_slew, SL0);
        chk("R1 drive", cfg_drive, DR0);
        chk("R1 stat", evt_status, 32'h0);
        chk("R1 eval", {31'b0, pin_eval}, 32'h0);
        acc(0, O_PU, 0, PU0, 0, "R1 read pu");

        // R2 / R11: plain write and change mask.
        acc(1, O_DOUT, 32'h1234_5678, 0, 0, "R2 wr dout");
        chk("R2 dout", cfg_dout, 32'h1234_5678);
        chk("R11 eval", {31'b0, pin_eval}, 32'h1);
        chk("R11 mask", pin_changed, 32'h1234_5678);
        acc(0, O_DOUT, 0, 32'h1234_5678, 0, "R2 rd dout");

        // R3: data aliases.
        acc(1, O_DSET, 32'h0000_000F, 0, 0, "R3 dset");
        chk("R3 dset val", cfg_dout, 32'h1234_567F);
        chk("R11 dset mask", pin_changed, 32'h0000_0007);
        acc(1, O_DCLR, 32'h1200_0000, 0, 0, "R3 dclr");
        chk("R3 dclr val", cfg_dout, 32'h0034_567F);
        chk("R11 dclr mask", pin_changed, 32'h1200_0000);
        // R3: enable aliases.
        acc(1, O_OE, 32'h0000_FF00, 0, 0, "R2 wr oe");
        acc(1, O_OSET, 32'h0000_00FF, 0, 0, "R3 oset");
        chk("R3 oset val", cfg_oe, 32'h0000_FFFF);
        acc(1, O_OCLR, 32'h0000_F000, 0, 0, "R3 oclr");
        chk("R3 oclr val", cfg_oe, 32'h0000_0FFF);
        chk("R11 oclr mask", pin_changed, 32'h0000_F000);
        // R11: same-value write still strobes with empty mask.
        acc(1, O_POL, 32'h0, 0, 0, "R11 pol same");
        chk("R11 pol eval", {31'b0, pin_eval}, 32'h1);
        chk("R11 pol mask", pin_changed, 32'h0);
        acc(1, O_PU, 32'h0000_0001, 0, 0, "R2 wr pu");
        chk("R11 pu mask", pin_changed, PU0 ^ 32'h1);
        // R3: event-enable aliases, no pin strobe.
        acc(1, O_EVEN, 32'h3, 0, 0, "R2 wr even");
        chk("R11 even no eval", {31'b0, pin_eval}, 32'h0);
        acc(1, O_ESET, 32'h30, 0, 0, "R3 eset");
        acc(1, O_ECLR, 32'h1, 0, 0, "R3 eclr");
        chk("R3 even val", cfg_evt_en, 32'h32);
        chk("R11 eclr no eval", {31'b0, pin_eval}, 32'h0);
        acc(1, O_EVT, 32'h0000_F0F0, 0, 0, "R2 wr evt");
        acc(0, O_EVT, 0, 32'h0000_F0F0, 0, "R2 rd evt");

        // R9: write-only reads.
        acc(0, O_DSET, 0, 32'h0, 1, "R9 rd dset");
        acc(0, O_LKA, 0, 32'h0, 1, "R9 rd locka");
        acc(0, O_ECLR, 0, 32'h0, 1, "R9 rd eclr");
        // R12: error does not linger.
        chk("R12 err pulse", {31'b0, bus_err}, 32'h1);
        @(negedge clk);
        chk("R12 err cleared", {31'b0, bus_err}, 32'h0);

        // R5: pin input register.
        pin_in_level = 32'hDEAD_BEEF;
        acc(0, O_PIN, 0, 32'hDEAD_BEEF, 0, "R5 rd pin");
        acc(1, O_PIN, 32'h1, 0, 1, "R5 wr pin");
        acc(0, O_PIN, 0, 32'hDEAD_BEEF, 0, "R5 rd pin again");

        // R4: sticky status, W1C, hit wins.
        evt_hit = 32'h0000_0105;
        @(negedge clk);
        evt_hit = 32'h0;
        acc(0, O_STAT, 0, 32'h0000_0105, 0, "R4 rd stat");
        acc(1, O_STAT, 32'h5, 0, 0, "R4 w1c");
        acc(0, O_STAT, 0, 32'h0000_0100, 0, "R4 after w1c");
        evt_hit = 32'h0000_0100;
        acc(1, O_STAT, 32'h0000_0100, 0, 0, "R4 tie");
        evt_hit = 32'h0;
        chk("R4 hit wins", evt_status, 32'h0000_0100);

        // R10: bad, misaligned, ignored offsets.
        acc(0, O_BAD, 0, 32'h0, 1, "R10 rd bad");
        acc(1, O_BAD, 32'hFFFF_FFFF, 0, 1, "R10 wr bad");
        acc(1, 12'h012, 32'hFFFF_FFFF, 0, 1, "R10 misaligned");
        chk("R10 dout kept", cfg_dout, 32'h0034_567F);
        acc(1, O_BLNK, 32'hFFFF_FFFF, 0, 0, "R10 wr blink");
        acc(0, O_BLNK, 0, 32'h0, 0, "R10 rd blink");
        chk("R10 blink no eval", {31'b0, pin_eval}, 32'h0);

        // R6 / R7: engage lock, writes discarded.
        acc(1, O_LKB, 32'h55, 0, 0, "R6 engage");
        acc(1, O_DOUT, 32'h0, 0, 1, "R7 locked dout");
        chk("R7 dout kept", cfg_dout, 32'h0034_567F);
        chk("R7 no eval", {31'b0, pin_eval}, 32'h0);
        acc(1, O_PU, 32'hFFFF_FFFF, 0, 1, "R7 locked pu");
        acc(0, O_PU, 0, 32'h0000_0001, 0, "R7 pu kept");

        // R8: wrong keys stay locked.
        acc(1, O_LKA, 32'hC0DE_FA73, 0, 0, "R8 key a alone");
        acc(1, O_DOUT, 32'h0, 0, 1, "R8 still locked 1");
        acc(1, O_LKB, 32'hC0DE_1248, 0, 0, "R8 key b");
        acc(1, O_LKA, 32'hC0DE_FA74, 0, 0, "R8 wrong a");
        acc(1, O_DOUT, 32'h0, 0, 1, "R8 still locked 2");
        acc(1, O_LKB, 32'h1234_0000, 0, 0, "R8 overwrite b");
        acc(1, O_LKA, 32'hC0DE_FA73, 0, 0, "R8 stale b");
        acc(1, O_DOUT, 32'h0, 0, 1, "R8 still locked 3");
        // R8: correct sequence releases.
        acc(1, O_LKB, 32'hC0DE_1248, 0, 0, "R8 key b ok");
        acc(1, O_LKA, 32'hC0DE_FA73, 0, 0, "R8 key a ok");
        acc(1, O_DOUT, 32'hAAAA_0000, 0, 0, "R8 unlocked wr");
        chk("R8 dout new", cfg_dout, 32'hAAAA_0000);
        chk("R11 unlock mask", pin_changed, 32'hAA9E_567F);
        // R8: release cleared second word; relock then key a alone fails.
        acc(1, O_LKA, 32'h0, 0, 0, "R6 relock via a");
        acc(1, O_LKA, 32'hC0DE_FA73, 0, 0, "R8 a after relock");
        acc(1, O_OE, 32'h0, 0, 1, "R8 relocked");
        chk("R8 oe kept", cfg_oe, 32'h0000_0FFF);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", sb_q.size(), 0);
        finished = 1;
        summary();
        $finish;
    end

endmodule